// File: doc/BRIEF.md
# Way-Pointer Reuse Mode Controller

This controller sits beside a set-associative instruction cache and its branch-target buffer. For each fetch it decides whether the cache may skip its tag comparison and enable only one data way. The decision uses hit-way indices that were recorded the last time the same branch was predicted the same way. It keeps one record per branch-target-buffer entry. Each record holds a valid flag, the branch address and predicted direction it was captured for, a count of valid pointers, and up to `NPTR` way pointers.

A three-state machine runs the table. In normal mode every fetch is a full tag check and nothing is kept. A buffer hit whose record is missing moves to tracing mode. There the controller notes the branch as pending and appends each fetch's hit-way. The next buffer hit writes those pointers into the pending branch's record. A buffer hit whose record is present moves to omitting mode. There the stored pointers are replayed one per fetch in the order they were captured, then control drops back to normal mode. A cache miss, a buffer replacement, a return-stack access or a misprediction cancels any trace or replay. A cache miss also wipes every record.

Top module: `wp_reuse_ctrl`

## Requirements
- R1: After reset the mode output is 0 (normal), every record is invalid, and `reuse_en` and `stall_req` are low.
- R2: A fetch with `btb_hit` whose indexed record is valid and matches both `pc` and `pred_taken` moves the mode to 2 (omitting). Each following fetch raises `reuse_en` and presents the stored pointers in capture order on `reuse_way`.
- R3: A fetch with `btb_hit` and no matching record moves the mode to 1 (tracing) and saves the index, PC and prediction. Every later fetch, including the one carrying the next `btb_hit`, appends its `hit_way`. The next `btb_hit` writes these pointers into the saved entry.
- R4: A fetch with `cache_miss`, `btb_repl`, `ras_access` or `mispredict` sets the mode to 0 on the next cycle. Any partial trace is discarded and no record is written.
- R5: A fetch with `cache_miss` invalidates every record at once and raises `stall_req` in that cycle.
- R6: In omitting mode, the fetch that uses the last valid pointer returns the mode to 0. Later fetches have `reuse_en` low.
- R7: A record write raises `stall_req` during the fetch that carries the triggering `btb_hit`. `stall_req` is high only for a record write or a cache miss.
- R8: A trace keeps at most `NPTR` pointers. Extra fetches are not recorded, and the record is written with count `NPTR`.
- R9: When a force-to-normal event and `btb_hit` share a cycle, the event wins. No record is written and no new mode is entered.
- R10: A record captured for one predicted direction is not reused when the same entry hits with the other direction.
- R11: A `btb_hit` on the very entry being written in that cycle sees the new record and enters omitting mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | A fetch happens this cycle |
| pc | input | PC_W | Address of the fetched instruction |
| btb_hit | input | 1 | Fetched instruction hits the branch-target buffer |
| btb_idx | input | $clog2(ENTRIES) | Buffer entry that hit |
| pred_taken | input | 1 | Predicted direction for the hitting branch |
| hit_way | input | $clog2(WAYS) | Way that satisfied this fetch's tag check |
| cache_miss | input | 1 | This fetch missed in the cache |
| btb_repl | input | 1 | A buffer entry is being replaced |
| ras_access | input | 1 | Return-address stack is used by this fetch |
| mispredict | input | 1 | A branch misprediction is signalled |
| reuse_en | output | 1 | Skip tag check and enable only `reuse_way` |
| reuse_way | output | $clog2(WAYS) | Way to enable when `reuse_en` is high |
| stall_req | output | 1 | One-cycle stall for a record write or global invalidation |
| mode | output | 2 | 0 normal, 1 tracing, 2 omitting |

## Verification
Assertions check the following on every cycle:
- the replay position always stays below the stored count while omitting;
- a cancelling event always lands in normal mode;
- a matching lookup always enters omitting mode at position zero;
- a clear leaves no valid record;
- the trace count never passes its limit;
- a stall never appears without a miss or a write from tracing mode.

Only the bench's scenarios show the rest:
- that pointers are replayed in the order they were captured;
- that a record is really absent after a cancelled trace, a direction mismatch or a global miss, seen as a fresh trace with no stall;
- that a saturated trace keeps its first four ways;
- that a same-entry hit uses the record written in that cycle.

// File: rtl/wp_pkg.sv
package wp_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_TRACE  = 2'd1,
    MODE_OMIT   = 2'd2
  } wp_mode_e;
endpackage

// File: rtl/wp_record_table.sv
module wp_record_table #(
  parameter int ENTRIES = 16,
  parameter int NPTR    = 4,
  parameter int PTR_W   = 2,
  parameter int CNT_W   = 3,
  parameter int PC_W    = 32,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int VEC_W  = NPTR * PTR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_all,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [PC_W-1:0]  wr_tag,
  input  logic             wr_pred,
  input  logic [VEC_W-1:0] wr_ptrs,
  input  logic [CNT_W-1:0] wr_cnt,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [PC_W-1:0]  rd_tag,
  input  logic             rd_pred,
  output logic             rd_ok,
  output logic [VEC_W-1:0] rd_ptrs,
  output logic [CNT_W-1:0] rd_cnt
);
  logic [ENTRIES-1:0] vld_q;
  logic [PC_W-1:0]    tag_q  [ENTRIES];
  logic               pred_q [ENTRIES];
  logic [VEC_W-1:0]   ptrs_q [ENTRIES];
  logic [CNT_W-1:0]   cnt_q  [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         vld_q <= '0;
    else if (clear_all) vld_q <= '0;
    else if (wr_en)     vld_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      pred_q[wr_idx] <= wr_pred;
      ptrs_q[wr_idx] <= wr_ptrs;
      cnt_q[wr_idx]  <= wr_cnt;
    end
  end

  // same-cycle write is forwarded to the lookup
  logic            byp;
  logic            sel_vld, sel_pred;
  logic [PC_W-1:0] sel_tag;
  always_comb begin
    byp      = wr_en && (wr_idx == rd_idx);
    sel_vld  = byp || vld_q[rd_idx];
    sel_tag  = byp ? wr_tag  : tag_q[rd_idx];
    sel_pred = byp ? wr_pred : pred_q[rd_idx];
    rd_ptrs  = byp ? wr_ptrs : ptrs_q[rd_idx];
    rd_cnt   = byp ? wr_cnt  : cnt_q[rd_idx];
    rd_ok    = sel_vld && (sel_tag == rd_tag) && (sel_pred == rd_pred);
  end

  p_clear_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clear_all |=> (vld_q == '0));
  p_write_sets_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clear_all) |=> vld_q[$past(wr_idx)]);
endmodule

// File: rtl/wp_trace_buf.sv
module wp_trace_buf #(
  parameter int NPTR  = 4,
  parameter int PTR_W = 2,
  parameter int CNT_W = 3,
  localparam int VEC_W = NPTR * PTR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             app_en,
  input  logic [PTR_W-1:0] way_in,
  output logic [VEC_W-1:0] view_ptrs,
  output logic [CNT_W-1:0] view_cnt
);
  logic [VEC_W-1:0] buf_q;
  logic [CNT_W-1:0] cnt_q;
  logic             full;

  function automatic logic [VEC_W-1:0] put_way(input logic [VEC_W-1:0] v,
                                                input logic [CNT_W-1:0] slot,
                                                input logic [PTR_W-1:0] w);
    logic [VEC_W-1:0] r;
    r = v;
    for (int i = 0; i < NPTR; i++)
      if (slot == CNT_W'(i)) r[i*PTR_W +: PTR_W] = w;
    return r;
  endfunction

  // contents as they stand once this fetch is appended
  always_comb begin
    full      = (cnt_q == CNT_W'(NPTR));
    view_ptrs = buf_q;
    view_cnt  = cnt_q;
    if (app_en && !full) begin
      view_ptrs = put_way(buf_q, cnt_q, way_in);
      view_cnt  = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      cnt_q <= '0;
    end else if (clr) begin
      buf_q <= '0;
      cnt_q <= '0;
    end else if (app_en) begin
      buf_q <= view_ptrs;
      cnt_q <= view_cnt;
    end
  end

  p_trace_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(NPTR));
  p_trace_hold_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (full && app_en && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/wp_mode_ctrl.sv
module wp_mode_ctrl
  import wp_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int NPTR    = 4,
  parameter int PTR_W   = 2,
  parameter int CNT_W   = 3,
  parameter int PC_W    = 32,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int VEC_W  = NPTR * PTR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_valid,
  input  logic             force_nm,
  input  logic             hit_ev,
  input  logic             look_ok,
  input  logic [VEC_W-1:0] look_ptrs,
  input  logic [CNT_W-1:0] look_cnt,
  input  logic [IDX_W-1:0] btb_idx,
  input  logic [PC_W-1:0]  pc,
  input  logic             pred_taken,
  output wp_mode_e         mode_q,
  output logic             reuse_en,
  output logic [PTR_W-1:0] reuse_way,
  output logic [IDX_W-1:0] pend_idx,
  output logic [PC_W-1:0]  pend_tag,
  output logic             pend_pred
);
  logic [VEC_W-1:0] wp_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] pos_q;
  logic [CNT_W-1:0] pos_nx;

  function automatic logic [PTR_W-1:0] way_at(input logic [VEC_W-1:0] v,
                                               input logic [CNT_W-1:0] slot);
    logic [PTR_W-1:0] r;
    r = '0;
    for (int i = 0; i < NPTR; i++)
      if (slot == CNT_W'(i)) r = v[i*PTR_W +: PTR_W];
    return r;
  endfunction

  assign pos_nx    = pos_q + CNT_W'(1);
  assign reuse_en  = fetch_valid && (mode_q == MODE_OMIT);
  assign reuse_way = reuse_en ? way_at(wp_q, pos_q) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MODE_NORMAL;
      wp_q      <= '0;
      cnt_q     <= '0;
      pos_q     <= '0;
      pend_idx  <= '0;
      pend_tag  <= '0;
      pend_pred <= 1'b0;
    end else if (fetch_valid) begin
      if (force_nm) begin
        mode_q <= MODE_NORMAL;
      end else if (hit_ev) begin
        if (look_ok) begin
          mode_q <= MODE_OMIT;
          wp_q   <= look_ptrs;
          cnt_q  <= look_cnt;
          pos_q  <= '0;
        end else begin
          mode_q    <= MODE_TRACE;
          pend_idx  <= btb_idx;
          pend_tag  <= pc;
          pend_pred <= pred_taken;
        end
      end else if (mode_q == MODE_OMIT) begin
        pos_q <= pos_nx;
        if (pos_nx >= cnt_q) mode_q <= MODE_NORMAL;
      end
    end
  end

  p_replay_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_OMIT) |-> (pos_q < cnt_q));
  p_force_normal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    force_nm |=> (mode_q == MODE_NORMAL));
  p_enter_omit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_ev && !force_nm && look_ok) |=> (mode_q == MODE_OMIT && pos_q == '0));
endmodule

// File: rtl/wp_reuse_ctrl.sv
module wp_reuse_ctrl
  import wp_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int NPTR    = 4,
  parameter int WAYS    = 4,
  parameter int PC_W    = 32,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int PTR_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int CNT_W  = $clog2(NPTR + 1),
  localparam int VEC_W  = NPTR * PTR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_valid,
  input  logic [PC_W-1:0]  pc,
  input  logic             btb_hit,
  input  logic [IDX_W-1:0] btb_idx,
  input  logic             pred_taken,
  input  logic [PTR_W-1:0] hit_way,
  input  logic             cache_miss,
  input  logic             btb_repl,
  input  logic             ras_access,
  input  logic             mispredict,
  output logic             reuse_en,
  output logic [PTR_W-1:0] reuse_way,
  output logic             stall_req,
  output logic [1:0]       mode
);
  wp_mode_e         mode_s;
  logic             force_nm, hit_ev, rec_wr, clear_all, trace_app, trace_clr;
  logic             look_ok, pend_pred;
  logic [VEC_W-1:0] look_ptrs, rec_ptrs;
  logic [CNT_W-1:0] look_cnt, rec_cnt;
  logic [IDX_W-1:0] pend_idx;
  logic [PC_W-1:0]  pend_tag;

  // named events shared by the sub-blocks and the assertions
  assign force_nm  = fetch_valid && (cache_miss || btb_repl || ras_access || mispredict);
  assign hit_ev    = fetch_valid && btb_hit && !force_nm;
  assign rec_wr    = hit_ev && (mode_s == MODE_TRACE);
  assign clear_all = fetch_valid && cache_miss;
  assign trace_app = fetch_valid && !force_nm && (mode_s == MODE_TRACE);
  assign trace_clr = force_nm || hit_ev;
  assign stall_req = clear_all || rec_wr;
  assign mode      = mode_s;

  wp_record_table #(.ENTRIES(ENTRIES), .NPTR(NPTR), .PTR_W(PTR_W),
                    .CNT_W(CNT_W), .PC_W(PC_W)) u_table (
    .clk(clk), .rst_n(rst_n), .clear_all(clear_all),
    .wr_en(rec_wr), .wr_idx(pend_idx), .wr_tag(pend_tag), .wr_pred(pend_pred),
    .wr_ptrs(rec_ptrs), .wr_cnt(rec_cnt),
    .rd_idx(btb_idx), .rd_tag(pc), .rd_pred(pred_taken),
    .rd_ok(look_ok), .rd_ptrs(look_ptrs), .rd_cnt(look_cnt)
  );

  wp_trace_buf #(.NPTR(NPTR), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_trace (
    .clk(clk), .rst_n(rst_n), .clr(trace_clr), .app_en(trace_app),
    .way_in(hit_way), .view_ptrs(rec_ptrs), .view_cnt(rec_cnt)
  );

  wp_mode_ctrl #(.ENTRIES(ENTRIES), .NPTR(NPTR), .PTR_W(PTR_W),
                 .CNT_W(CNT_W), .PC_W(PC_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid),
    .force_nm(force_nm), .hit_ev(hit_ev), .look_ok(look_ok),
    .look_ptrs(look_ptrs), .look_cnt(look_cnt), .btb_idx(btb_idx),
    .pc(pc), .pred_taken(pred_taken), .mode_q(mode_s),
    .reuse_en(reuse_en), .reuse_way(reuse_way),
    .pend_idx(pend_idx), .pend_tag(pend_tag), .pend_pred(pend_pred)
  );

  p_stall_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall_req |-> (cache_miss || mode_s == MODE_TRACE));
  p_no_write_on_force_r9: assert property (@(posedge clk) disable iff (!rst_n)
    force_nm |-> !rec_wr);
endmodule

// File: tb/wp_reuse_ctrl_bench.sv
module wp_reuse_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fetch_valid = 0, btb_hit = 0, pred_taken = 0;
  logic cache_miss = 0, btb_repl = 0, ras_access = 0, mispredict = 0;
  logic [31:0] pc = '0;
  logic [3:0]  btb_idx = '0;
  logic [1:0]  hit_way = '0;
  logic        reuse_en, stall_req;
  logic [1:0]  reuse_way, mode;

  always #5 clk = ~clk;

  wp_reuse_ctrl u_wp_reuse_ctrl (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .pc(pc),
    .btb_hit(btb_hit), .btb_idx(btb_idx), .pred_taken(pred_taken),
    .hit_way(hit_way), .cache_miss(cache_miss), .btb_repl(btb_repl),
    .ras_access(ras_access), .mispredict(mispredict),
    .reuse_en(reuse_en), .reuse_way(reuse_way), .stall_req(stall_req),
    .mode(mode)
  );

  typedef struct {
    string      rq;
    logic       er;
    logic [1:0] ew;
    logic       es;
    logic [1:0] em;
  } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  localparam logic [31:0] PA = 32'h100, PB = 32'h140, PCC = 32'h200, PD = 32'h240;

  task automatic check(string rq, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, expv);
    end
  endtask

  // one cycle: drive at the falling edge and queue the expected result
  task automatic step(string rq, logic fv, logic [31:0] a, logic h, logic [3:0] ix,
                      logic pr, logic [1:0] w, logic ms, logic rp, logic rs, logic mp,
                      logic er, logic [1:0] ew, logic es, logic [1:0] em);
    exp_t e;
    @(negedge clk);
    fetch_valid = fv; pc = a; btb_hit = h; btb_idx = ix; pred_taken = pr;
    hit_way = w; cache_miss = ms; btb_repl = rp; ras_access = rs; mispredict = mp;
    e.rq = rq; e.er = er; e.ew = ew; e.es = es; e.em = em;
    q.push_back(e);
  endtask

  task automatic fet(string rq, logic [1:0] w, logic er, logic [1:0] ew, logic [1:0] em);
    step(rq, 1, 32'h300, 0, 0, 0, w, 0, 0, 0, 0, er, ew, 0, em);
  endtask

  task automatic hit(string rq, logic [31:0] a, logic [3:0] ix, logic pr, logic [1:0] w,
                     logic es, logic [1:0] em);
    step(rq, 1, a, 1, ix, pr, w, 0, 0, 0, 0, 0, 0, es, em);
  endtask

  // monitor: combinational outputs before the rising edge, mode after it
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (q.size() > 0) begin
        exp_t e;
        logic ar, as;
        logic [1:0] aw;
        e = q.pop_front();
        ar = reuse_en; aw = reuse_way; as = stall_req;
        @(posedge clk);
        #1;
        check(e.rq, "reuse_en", int'(ar), int'(e.er));
        if (e.er) check(e.rq, "reuse_way", int'(aw), int'(e.ew));
        check(e.rq, "stall_req", int'(as), int'(e.es));
        check(e.rq, "mode", int'(mode), int'(e.em));
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #3;
    check("R1", "mode", int'(mode), 0);
    check("R1", "reuse_en", int'(reuse_en), 0);
    check("R1", "stall_req", int'(stall_req), 0);

    // R3: trace after branch A, recorded ways 1,3,0 (last from branch B fetch)
    hit("R3", PA, 3, 1, 0, 0, 1);
    fet("R3", 1, 0, 0, 1);
    fet("R3", 3, 0, 0, 1);
    hit("R7", PB, 7, 1, 0, 1, 1);   // R7: write of A record stalls
    hit("R2", PA, 3, 1, 2, 1, 2);   // writes B {2}; A record valid -> omit
    fet("R2", 0, 1, 1, 2);
    fet("R2", 0, 1, 3, 2);
    fet("R6", 0, 1, 0, 0);          // R6: last pointer -> normal
    fet("R6", 0, 0, 0, 0);
    hit("R3", PB, 7, 1, 0, 0, 2);   // B record {2}
    fet("R3", 0, 1, 2, 0);
    // R10: same entry, opposite direction is not reused
    hit("R10", PA, 3, 0, 0, 0, 1);
    fet("R10", 1, 0, 0, 1);
    step("R4", 1, 32'h300, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    hit("R4", PA, 3, 0, 0, 0, 1);   // no record left behind by cancelled trace
    // R8: five traced fetches, only first four kept
    fet("R8", 0, 0, 0, 1);
    fet("R8", 1, 0, 0, 1);
    fet("R8", 2, 0, 0, 1);
    fet("R8", 3, 0, 0, 1);
    fet("R8", 3, 0, 0, 1);
    hit("R8", PB, 7, 1, 1, 1, 2);
    fet("R8", 0, 1, 2, 0);
    hit("R8", PA, 3, 0, 0, 0, 2);
    fet("R8", 0, 1, 0, 2);
    fet("R8", 0, 1, 1, 2);
    fet("R8", 0, 1, 2, 2);
    fet("R8", 0, 1, 3, 0);
    // R9: hit together with replacement
    hit("R9", PCC, 5, 1, 0, 0, 1);
    fet("R9", 2, 0, 0, 1);
    step("R9", 1, PD, 1, 9, 1, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    hit("R9", PCC, 5, 1, 0, 0, 1);  // no stall, no record for C
    hit("R11", PCC, 5, 1, 1, 1, 2); // writes C {1} and hits it at once
    fet("R11", 0, 1, 1, 0);
    // R5: miss clears everything
    step("R5", 1, 32'h300, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 1, 0);
    hit("R5", PA, 3, 0, 0, 0, 1);
    hit("R5", PB, 7, 1, 0, 1, 1);
    step("R4", 1, 32'h300, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    step("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

    while (q.size() > 0) @(posedge clk);
    repeat (3) @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule